// File: doc/BRIEF.md
# Continuous Repetition and Stuck-Output Monitor

This block is an always-on health monitor for a random bit source. It follows every accepted raw bit and keeps the length of the current run of equal bits. When a run reaches a first length it reports a long-run failure. When the same run reaches a second, greater length it reports a noise failure. In parallel it compares each accepted output word with the word accepted just before it, and reports a stuck output when the two are equal. No sampling window is involved.

Every failure event also feeds a saturating alarm counter. When an event brings the counter to the programmed threshold, the block raises a shutdown output and a shutdown-overflow flag. The surrounding logic uses the shutdown output to stop the entropy source. Shutdown stays asserted until a restart pulse arrives. The restart also clears the counter and all run and word history. The four flags are sticky, and each one is cleared by its own bit of a clear pulse.

Top module: `rep_monitor`

## Requirements
- R1: After reset, flags_o is 0 and shutdown_o is 0.
- R2: When bit_vld_i is high, bit_i is accepted at the clock edge. The LONG_RUN-th (default 34) consecutive equal accepted bit sets flags_o[0] after that edge. A run that is one bit shorter leaves flags_o[0] clear.
- R3: The NOISE_RUN-th (default 48) consecutive equal accepted bit sets flags_o[1]. A run of NOISE_RUN-1 bits leaves flags_o[1] clear.
- R4: An accepted bit that differs from the previous accepted bit restarts the run count at 1. Cycles with bit_vld_i low neither count toward a run nor break it.
- R5: The run count saturates. A run of any length raises at most one long-run event and at most one noise event.
- R6: An accepted word (word_vld_i high) that equals the previous accepted word sets flags_o[2]. A word that differs from the previous one does not set it.
- R7: The first word accepted after reset or restart is not compared with anything.
- R8: Each long-run, noise or stuck event adds one to an 8-bit saturating alarm counter. If a cycle with at least one event leaves the count at or above alarm_thresh_i, shutdown_o and flags_o[3] are set after that edge. A threshold of 0 or 1 therefore trips on the first event.
- R9: shutdown_o stays high until restart_i. restart_i clears shutdown_o, the alarm count, and the bit and word history. It leaves flags_o unchanged.
- R10: Each flag is sticky. flag_clr_i[i] clears only flags_o[i]. A new event for a flag in the same cycle as its clear leaves that flag set.
- R11: A bit or word presented in the same cycle as restart_i is discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| bit_vld_i | input | 1 | Raw bit valid |
| bit_i | input | 1 | Raw bit |
| word_vld_i | input | 1 | Output word valid |
| word_i | input | WORD_W | Output word |
| alarm_thresh_i | input | CNT_W | Alarm count that triggers shutdown |
| restart_i | input | 1 | Restart pulse: clears shutdown, counter and history |
| flag_clr_i | input | 4 | Per-flag clear pulse (0 long, 1 noise, 2 stuck, 3 shutdown overflow) |
| flags_o | output | 4 | Sticky flags, same bit order as flag_clr_i |
| shutdown_o | output | 1 | Shutdown request, held until restart |

## Verification
The assertions assume that every input is known and synchronous to clk_i from the first edge after reset. They also assume that restart_i and flag_clr_i are level inputs, sampled once per edge, so a long pulse acts as several pulses. The threshold may change at any time, because the alarm counter compares against the value present at each event. The bench drives every input from time zero and changes inputs only on the falling edge. It biases the random bit stream toward long runs and the words toward a small set of values, so run alarms, repeats and shutdowns occur often.

// File: rtl/rep_mon_pkg.sv
package rep_mon_pkg;
  localparam int FLAG_N   = 4;
  localparam int FL_LONG  = 0;
  localparam int FL_NOISE = 1;
  localparam int FL_STUCK = 2;
  localparam int FL_OFLO  = 3;
endpackage

// File: rtl/run_len_det.sv
module run_len_det #(
  parameter int LONG_RUN  = 34,
  parameter int NOISE_RUN = 48
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic bit_vld_i,
  input  logic bit_i,
  input  logic restart_i,
  output logic long_evt_o,
  output logic noise_evt_o
);
  localparam int RUN_W = $clog2(NOISE_RUN + 1);

  logic [RUN_W-1:0] run_q;
  logic             last_q, have_q;
  logic             take, same, inc;

  assign take = bit_vld_i & ~restart_i;
  assign same = have_q & (bit_i == last_q);
  // count stops at NOISE_RUN so each threshold is crossed once per run
  assign inc  = take & same & (run_q < RUN_W'(NOISE_RUN));
  assign long_evt_o  = inc & (run_q == RUN_W'(LONG_RUN - 1));
  assign noise_evt_o = inc & (run_q == RUN_W'(NOISE_RUN - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_q  <= '0;
      last_q <= 1'b0;
      have_q <= 1'b0;
    end else if (restart_i) begin
      run_q  <= '0;
      have_q <= 1'b0;
    end else if (take) begin
      last_q <= bit_i;
      have_q <= 1'b1;
      if (!same)    run_q <= RUN_W'(1);
      else if (inc) run_q <= run_q + RUN_W'(1);
    end
  end

  // R4
  run_restart_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (take && have_q && (bit_i != last_q)) |=> (run_q == RUN_W'(1)));

  // R2
  long_cnt_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    long_evt_o |=> (run_q == RUN_W'(LONG_RUN)));
endmodule

// File: rtl/word_rep_det.sv
module word_rep_det #(
  parameter int WORD_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              word_vld_i,
  input  logic [WORD_W-1:0] word_i,
  input  logic              restart_i,
  output logic              rep_evt_o
);
  logic [WORD_W-1:0] prev_q;
  logic              have_q;
  logic              take;

  assign take      = word_vld_i & ~restart_i;
  assign rep_evt_o = take & have_q & (word_i == prev_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prev_q <= '0;
      have_q <= 1'b0;
    end else if (restart_i) begin
      have_q <= 1'b0;
    end else if (take) begin
      prev_q <= word_i;
      have_q <= 1'b1;
    end
  end

  // R7
  first_word_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    restart_i |=> !rep_evt_o);
endmodule

// File: rtl/alarm_ctr.sv
module alarm_ctr #(
  parameter int CNT_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [1:0]       ev_cnt_i,
  input  logic [CNT_W-1:0] thresh_i,
  input  logic             restart_i,
  output logic             trip_o,
  output logic             shut_o
);
  localparam int SUM_W = CNT_W + 2;
  localparam logic [SUM_W-1:0] CNT_MAX = SUM_W'((1 << CNT_W) - 1);

  logic [CNT_W-1:0] cnt_q, cnt_nxt;
  logic [SUM_W-1:0] sum;
  logic             shut_q;

  assign sum     = {2'b00, cnt_q} + {{CNT_W{1'b0}}, ev_cnt_i};
  assign cnt_nxt = (sum > CNT_MAX) ? CNT_MAX[CNT_W-1:0] : sum[CNT_W-1:0];
  assign trip_o  = (ev_cnt_i != 2'd0) & (cnt_nxt >= thresh_i);
  assign shut_o  = shut_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      shut_q <= 1'b0;
    end else if (restart_i) begin
      cnt_q  <= '0;
      shut_q <= 1'b0;
    end else begin
      cnt_q <= cnt_nxt;
      if (trip_o) shut_q <= 1'b1;
    end
  end

  // R8
  idle_cnt_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!restart_i && ev_cnt_i == 2'd0) |=> $stable(cnt_q));

  // R8
  no_wrap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!restart_i && $past(cnt_q) == CNT_MAX[CNT_W-1:0] && !$past(restart_i))
      |-> (cnt_q != '0 || $past(ev_cnt_i) == 2'd0));
endmodule

// File: rtl/rep_monitor.sv
module rep_monitor
  import rep_mon_pkg::*;
#(
  parameter int WORD_W    = 16,
  parameter int LONG_RUN  = 34,
  parameter int NOISE_RUN = 48,
  parameter int CNT_W     = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              bit_vld_i,
  input  logic              bit_i,
  input  logic              word_vld_i,
  input  logic [WORD_W-1:0] word_i,
  input  logic [CNT_W-1:0]  alarm_thresh_i,
  input  logic              restart_i,
  input  logic [FLAG_N-1:0] flag_clr_i,
  output logic [FLAG_N-1:0] flags_o,
  output logic              shutdown_o
);
  logic              long_evt, noise_evt, rep_evt, trip;
  logic [1:0]        ev_cnt;
  logic [FLAG_N-1:0] set_vec, flags_q;

  run_len_det #(.LONG_RUN(LONG_RUN), .NOISE_RUN(NOISE_RUN)) u_run (
    .clk_i, .rst_ni, .bit_vld_i, .bit_i, .restart_i,
    .long_evt_o(long_evt), .noise_evt_o(noise_evt)
  );

  word_rep_det #(.WORD_W(WORD_W)) u_word (
    .clk_i, .rst_ni, .word_vld_i, .word_i, .restart_i,
    .rep_evt_o(rep_evt)
  );

  assign ev_cnt = {1'b0, long_evt} + {1'b0, noise_evt} + {1'b0, rep_evt};

  alarm_ctr #(.CNT_W(CNT_W)) u_alarm (
    .clk_i, .rst_ni, .ev_cnt_i(ev_cnt), .thresh_i(alarm_thresh_i),
    .restart_i, .trip_o(trip), .shut_o(shutdown_o)
  );

  always_comb begin
    set_vec           = '0;
    set_vec[FL_LONG]  = long_evt;
    set_vec[FL_NOISE] = noise_evt;
    set_vec[FL_STUCK] = rep_evt;
    set_vec[FL_OFLO]  = trip;
  end

  // set beats clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) flags_q <= '0;
    else         flags_q <= (flags_q & ~flag_clr_i) | set_vec;
  end

  assign flags_o = flags_q;

  // R9
  shut_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (shutdown_o && !restart_i) |=> shutdown_o);

  // R9
  restart_clr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    restart_i |=> !shutdown_o);

  // R10
  sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> ((~flags_o & $past(flags_o & ~flag_clr_i)) == '0));

  // R8
  oflo_flag_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(shutdown_o) |-> flags_o[FL_OFLO]);

  // R11
  restart_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    restart_i |=> ((flags_o & ~$past(flags_o & ~flag_clr_i)) == '0));
endmodule

// File: tb/rep_monitor_tb.sv
module rep_monitor_tb;
  localparam int WORD_W = 16;
  localparam int LONG_N = 34;
  localparam int NOISE_N = 48;

  logic              clk_i = 1'b0;
  logic              rst_ni = 1'b0;
  logic              bit_vld_i = 1'b0, bit_i = 1'b0;
  logic              word_vld_i = 1'b0;
  logic [WORD_W-1:0] word_i = '0;
  logic [7:0]        alarm_thresh_i = 8'hff;
  logic              restart_i = 1'b0;
  logic [3:0]        flag_clr_i = '0;
  logic [3:0]        flags_o;
  logic              shutdown_o;

  int total = 0, fails = 0, cyc = 0;
  bit done = 0;

  // bench model state
  int          m_run, m_alarm;
  logic        m_last, m_have, m_havew, m_shut;
  logic [WORD_W-1:0] m_prevw;
  logic [3:0]  m_flags;

  rep_monitor u_dut (
    .clk_i, .rst_ni, .bit_vld_i, .bit_i, .word_vld_i, .word_i,
    .alarm_thresh_i, .restart_i, .flag_clr_i, .flags_o, .shutdown_o
  );

  always #4 clk_i = ~clk_i;

  function void model_reset();
    m_run = 0; m_alarm = 0; m_last = 0; m_have = 0;
    m_havew = 0; m_shut = 0; m_prevw = '0; m_flags = '0;
  endfunction

  function void model_step(logic bv, logic b, logic wv, logic [WORD_W-1:0] w,
                           logic rs, logic [3:0] clr, logic [7:0] thr);
    logic el, en, es, eo;
    int n;
    el = 0; en = 0; es = 0; eo = 0;
    if (rs) begin
      m_run = 0; m_have = 0; m_havew = 0; m_alarm = 0; m_shut = 0;
    end else begin
      if (bv) begin
        if (m_have && b == m_last) begin
          if (m_run < NOISE_N) begin
            m_run++;
            if (m_run == LONG_N) el = 1;
            if (m_run == NOISE_N) en = 1;
          end
        end else m_run = 1;
        m_last = b; m_have = 1;
      end
      if (wv) begin
        if (m_havew && w == m_prevw) es = 1;
        m_prevw = w; m_havew = 1;
      end
      n = int'(el) + int'(en) + int'(es);
      if (n > 0) begin
        m_alarm = (m_alarm + n > 255) ? 255 : m_alarm + n;
        if (m_alarm >= int'(thr)) begin m_shut = 1; eo = 1; end
      end
    end
    m_flags = (m_flags & ~clr) | {eo, es, en, el};
  endfunction

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic step(logic bv, logic b, logic wv, logic [WORD_W-1:0] w,
                      logic rs, logic [3:0] clr);
    logic [3:0] d;
    string tg;
    bit_vld_i = bv; bit_i = b; word_vld_i = wv; word_i = w;
    restart_i = rs; flag_clr_i = clr;
    @(posedge clk_i);
    model_step(bv, b, wv, w, rs, clr, alarm_thresh_i);
    @(negedge clk_i);
    d = flags_o ^ m_flags;
    tg = d[0] ? "R2 model flags" : d[1] ? "R3 model flags" :
         d[2] ? "R6 model flags" : "R8 model flags";
    check(tg, 32'(flags_o), 32'(m_flags));
    check("R9 model shutdown", 32'(shutdown_o), 32'(m_shut));
    bit_vld_i = 0; word_vld_i = 0; restart_i = 0; flag_clr_i = '0;
  endtask

  task automatic bits(int n, logic b);
    for (int i = 0; i < n; i++) step(1, b, 0, '0, 0, '0);
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) step(0, 0, 0, '0, 0, '0);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  endtask

  always @(posedge clk_i) begin
    cyc++;
    if (cyc == 150000 && !done) begin
      total++; fails++;
      $display("FAIL watchdog act=%0d exp=done", cyc);
      finish_run();
    end
  end

  initial begin
    logic cur;
    void'($urandom(32'h5eed_0042));
    model_reset();
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    check("R1 flags", 32'(flags_o), 0);
    check("R1 shutdown", 32'(shutdown_o), 0);

    // R2 / R3 thresholds
    bits(33, 1);
    check("R2 33 bits", 32'(flags_o), 0);
    bits(1, 1);
    check("R2 34 bits", 32'(flags_o), 1);
    bits(13, 1);
    check("R3 47 bits", 32'(flags_o), 1);
    bits(1, 1);
    check("R3 48 bits", 32'(flags_o), 3);
    step(0, 0, 0, '0, 0, 4'hf);
    check("R10 clear all", 32'(flags_o), 0);
    bits(60, 1);
    check("R5 saturated run", 32'(flags_o), 0);

    // R4 run restart and gaps
    step(0, 0, 0, '0, 1, '0);
    bits(20, 0);
    for (int i = 0; i < 5; i++) step(0, 1, 0, '0, 0, '0);
    bits(14, 0);
    check("R4 gap kept run", 32'(flags_o), 1);
    step(0, 0, 0, '0, 0, 4'h1);
    bits(1, 1);
    bits(33, 0);
    check("R4 reset to one", 32'(flags_o), 0);
    bits(1, 0);
    check("R4 34 after flip", 32'(flags_o), 1);

    // R5 / R8 escalation
    step(0, 0, 0, '0, 1, 4'hf);
    alarm_thresh_i = 8'd3;
    bits(100, 1);
    check("R5 two events only", 32'(shutdown_o), 0);
    alarm_thresh_i = 8'd2;
    step(0, 0, 0, '0, 1, '0);
    bits(100, 1);
    check("R8 shutdown trip", 32'(shutdown_o), 1);
    check("R8 flags", 32'(flags_o), 32'hb);

    // R9 hold and restart
    idle(10);
    check("R9 held", 32'(shutdown_o), 1);
    step(0, 0, 0, '0, 1, '0);
    check("R9 restart clears", 32'(shutdown_o), 0);
    check("R9 flags kept", 32'(flags_o), 32'hb);

    // R6 / R7 words
    alarm_thresh_i = 8'hff;
    step(0, 0, 0, '0, 0, 4'hf);
    step(0, 0, 1, 16'h1234, 0, '0);
    check("R7 first word", 32'(flags_o), 0);
    step(0, 0, 1, 16'h1234, 0, '0);
    check("R6 repeat", 32'(flags_o), 4);
    step(0, 0, 0, '0, 0, 4'hf);
    step(0, 0, 1, 16'h55aa, 0, '0);
    step(0, 0, 1, 16'h0f0f, 0, '0);
    check("R6 differ", 32'(flags_o), 0);
    step(0, 0, 0, '0, 1, '0);
    step(0, 0, 1, 16'h0f0f, 0, '0);
    check("R7 after restart", 32'(flags_o), 0);

    // R10 set beats clear, per-bit clear
    step(0, 0, 1, 16'h0f0f, 0, 4'h4);
    check("R10 set wins", 32'(flags_o), 4);
    step(0, 0, 0, '0, 0, 4'h1);
    check("R10 other bit", 32'(flags_o), 4);
    step(0, 0, 0, '0, 0, 4'h4);
    check("R10 own bit", 32'(flags_o), 0);

    // R11 input on restart cycle discarded
    step(0, 0, 1, 16'h7777, 1, '0);
    step(0, 0, 1, 16'h7777, 0, '0);
    check("R11 word dropped", 32'(flags_o), 0);

    // R8 threshold zero
    alarm_thresh_i = 8'd0;
    step(0, 0, 0, '0, 1, '0);
    step(0, 0, 1, 16'h0001, 0, '0);
    check("R8 thr0 no event", 32'(shutdown_o), 0);
    step(0, 0, 1, 16'h0001, 0, '0);
    check("R8 thr0 trip", 32'(shutdown_o), 1);
    step(0, 0, 0, '0, 1, 4'hf);

    // constrained random against the model
    cur = 0;
    for (int i = 0; i < 4000; i++) begin
      logic bv, wv, rs;
      logic [3:0] clr;
      logic [WORD_W-1:0] w;
      if ($urandom % 300 == 0) alarm_thresh_i = 8'($urandom % 6);
      if ($urandom % 40 == 0) cur = ~cur;
      bv  = ($urandom % 8) != 0;
      wv  = ($urandom % 4) == 0;
      w   = WORD_W'($urandom % 3);
      rs  = ($urandom % 400) == 0;
      clr = ($urandom % 50 == 0) ? 4'($urandom) : 4'h0;
      step(bv, cur, wv, w, rs, clr);
    end
    finish_run();
  end
endmodule